// File: doc/BRIEF.md
# Receive Buffer DMA Engine

This block moves packets from a receive packet queue into host memory, one host buffer for each software request. Software posts a 64-bit request word that holds the buffer address and its size. The engine takes the head packet of the queue and issues one write burst to memory. The burst carries the packet bytes that fit in the buffer. When the burst has completed, the engine publishes a 32-bit completion word and pulses an interrupt.

A packet larger than the buffer is split across several requests. The engine keeps the bytes still owed and the read offset into the packet. It flags each partial completion with a More bit. The packet leaves the queue only when its last byte has been written. Checksum and protocol classification happen upstream: the flags travel with each packet at the queue head. The memory write completes after a modelled latency. That latency is a fixed base plus a charge for each started 64-byte chunk.

Software reads back the completion word through a read port. The read also returns the queue occupancy, saturated to eight bits. A read that arrives while a transfer is in flight is held until the engine is idle again.

Top module: `rxdma_engine`

## Requirements
- R1: The request word carries the buffer address in bits [ADDR_W-1:0] and the buffer length in bits [32+LEN_W-1:32]. A request accepted while idle clears the completion word. It moves the engine to packet wait when `rx_enable` is high. With `rx_enable` low the engine stays idle and issues no memory write.
- R2: A request written while the engine is not idle is ignored: the transfer in flight keeps its address and length, and `req_err` is high in that cycle.
- R3: While waiting, the engine stays put as long as the queue is empty and no packet is partly consumed. Once a packet is present it takes that packet's length and flags.
- R4: The write burst presents the buffer address, a length equal to the smaller of the buffer length and the bytes left in the packet, and the byte offset into the packet.
- R5: The interrupt pulse begins on rising edge L+1 after the edge that accepts the memory write. L = LAT_BASE + ceil(length/64) * LAT_PER64.
- R6: Completion word layout: [15:0] copied length; [16] IP; [17] TCP; [18] UDP; [19] IP checksum error; [20] TCP checksum error; [21] UDP checksum error; [29:22] zero; [30] More; [31] Complete (always 1 after a transfer).
- R7: When bytes of the packet remain, More is set. The remaining count falls by the copied length and the offset rises by it. The next request continues the same packet without waiting on the queue.
- R8: `pkt_pop` pulses for one cycle exactly when the last bytes of a packet have been written, and never on a partial copy.
- R9: `irq_rxdata` is a one-cycle pulse per completed transfer, after which the engine is idle.
- R10: A read in an idle cycle is answered one cycle later. It returns the completion word in [31:0] and the queue count in [39:32], saturated at 255. Bits [63:40] are zero.
- R11: A read that arrives while the engine is busy is held. It is answered one cycle after the engine returns to idle, with the updated completion word.
- R12: After reset the engine is idle, the completion word reads as zero, and no memory write, pop or interrupt is asserted.
- R13: Flags TCP and UDP are never both set on a latched packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receive enable |
| req_wr | input | 1 | Request word write strobe |
| req_word | input | 64 | Request word (address, length) |
| req_err | output | 1 | Request written while busy |
| pkt_valid | input | 1 | Queue holds at least one packet |
| pkt_len | input | LEN_W | Byte length of the head packet |
| pkt_flags | input | 6 | Protocol and error flags of the head packet |
| pkt_pop | output | 1 | Remove the head packet |
| fifo_count | input | CNT_W | Packets queued |
| mem_valid | output | 1 | Write burst request |
| mem_ready | input | 1 | Memory accepts the burst |
| mem_addr | output | ADDR_W | Host byte address |
| mem_len | output | LEN_W | Burst byte length |
| mem_offset | output | LEN_W | Byte offset into the head packet |
| rd_req | input | 1 | Completion word read request |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 64 | Completion word plus queue count |
| irq_rxdata | output | 1 | Transfer done interrupt pulse |

## Verification
A request reaches the memory port two edges after the write when a packet is waiting. The interrupt then follows L+1 edges after the accepting edge, and the read answer comes one edge after a request seen in idle. The bench counts falling edges from the observed handshake to the interrupt and compares the count with the latency formula. It samples every output on falling edges, so each value is read one half-cycle after the edge that produced it. Held reads are checked by confirming `rd_valid` stays low through the stall. It must then rise exactly two falling edges after the interrupt is seen.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_BEGIN = 3'd2,
      ST_COPY  = 3'd3,
      ST_DONE  = 3'd4
   } rx_state_e;

   localparam int FLAG_W      = 6;
   localparam int DW_LEN_W    = 16;
   localparam int DW_FLAG_LSB = 16;
   localparam int DW_MORE     = 30;
   localparam int DW_CMPL     = 31;
   localparam int DW_CNT_LSB  = 32;
   localparam int REQ_LEN_LSB = 32;

   localparam int FL_TCP = 1;
   localparam int FL_UDP = 2;

   function automatic logic [7:0] sat_count(input logic [31:0] n);
      return (n > 32'd255) ? 8'hFF : n[7:0];
   endfunction

endpackage

// File: rtl/rxdma_copy_timer.sv
module rxdma_copy_timer #(
   parameter int LEN_W     = 16,
   parameter int LAT_BASE  = 4,
   parameter int LAT_PER64 = 2,
   parameter int LAT_W     = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] len,
   input  logic             tick,
   output logic             expired
);
   localparam int CHUNK_LG = 6;

   logic [LAT_W-1:0] cnt;
   logic [LAT_W-1:0] load_val;
   logic [LEN_W:0]   chunks;

   assign chunks = ({1'b0, len} + (LEN_W+1)'((2**CHUNK_LG) - 1)) >> CHUNK_LG;

   generate
      if (LAT_BASE >= (2**LAT_W)) begin : g_chk_base
         $error("LAT_W too small for LAT_BASE");
      end
      if (LAT_PER64 == 0) begin : g_flat
         logic unused_chunks;
         assign unused_chunks = ^chunks;
         assign load_val = LAT_W'(LAT_BASE);
      end else begin : g_scaled
         assign load_val = LAT_W'(LAT_BASE) + LAT_W'(chunks) * LAT_W'(LAT_PER64);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt <= '0;
      else if (load)               cnt <= load_val;
      else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/rxdma_read_port.sv
module rxdma_read_port
   import rxdma_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  logic             engine_idle,
   input  logic [31:0]      done_word,
   input  logic [CNT_W-1:0] fifo_count,
   output logic             rd_valid,
   output logic [63:0]      rd_data
);
   logic pend;
   logic want;

   assign want = pend | rd_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend     <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         if (want && engine_idle) begin
            pend     <= 1'b0;
            rd_valid <= 1'b1;
            rd_data  <= {24'b0, sat_count(32'(fifo_count)), done_word};
         end else if (rd_req) begin
            pend <= 1'b1;
         end
      end
   end

   a_r11_answer_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(engine_idle));
   a_r10_count_saturated: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_data[63:40] == '0));

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
   import rxdma_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int CNT_W     = 10,
   parameter int LAT_BASE  = 4,
   parameter int LAT_PER64 = 2,
   parameter int LAT_W     = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_enable,
   input  logic              req_wr,
   input  logic [63:0]       req_word,
   output logic              req_err,
   input  logic              pkt_valid,
   input  logic [LEN_W-1:0]  pkt_len,
   input  logic [5:0]        pkt_flags,
   output logic              pkt_pop,
   input  logic [CNT_W-1:0]  fifo_count,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LEN_W-1:0]  mem_len,
   output logic [LEN_W-1:0]  mem_offset,
   input  logic              rd_req,
   output logic              rd_valid,
   output logic [63:0]       rd_data,
   output logic              irq_rxdata
);
   generate
      if (ADDR_W > 32 || ADDR_W < 1) begin : g_chk_addr
         $error("ADDR_W must be 1..32");
      end
      if (LEN_W > DW_LEN_W || LEN_W < 1) begin : g_chk_len
         $error("LEN_W must be 1..16");
      end
   endgenerate

   rx_state_e         state;
   logic [ADDR_W-1:0] buf_addr;
   logic [LEN_W-1:0]  buf_len;
   logic [LEN_W-1:0]  rem;
   logic [LEN_W-1:0]  offset;
   logic [5:0]        flags_q;
   logic              have_part;
   logic [LEN_W-1:0]  cp_len;
   logic [LEN_W-1:0]  cp_len_q;
   logic [31:0]       done_word;
   logic              accept;
   logic              last;
   logic              tmr_expired;
   logic              unused_req;

   assign unused_req = ^req_word;
   assign req_err    = req_wr && (state != ST_IDLE);
   assign cp_len     = (buf_len < rem) ? buf_len : rem;
   assign accept     = (state == ST_BEGIN) && mem_ready;
   assign last       = (rem == cp_len_q);

   assign mem_valid  = (state == ST_BEGIN);
   assign mem_addr   = buf_addr;
   assign mem_len    = cp_len;
   assign mem_offset = offset;
   assign pkt_pop    = (state == ST_DONE) && last;
   assign irq_rxdata = (state == ST_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         buf_addr  <= '0;
         buf_len   <= '0;
         rem       <= '0;
         offset    <= '0;
         flags_q   <= '0;
         have_part <= 1'b0;
         cp_len_q  <= '0;
         done_word <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_wr) begin
                  buf_addr  <= req_word[ADDR_W-1:0];
                  buf_len   <= req_word[REQ_LEN_LSB +: LEN_W];
                  done_word <= '0;
                  if (rx_enable) state <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (have_part) begin
                  state <= ST_BEGIN;
               end else if (pkt_valid) begin
                  rem       <= pkt_len;
                  offset    <= '0;
                  flags_q   <= pkt_flags;
                  have_part <= 1'b1;
                  state     <= ST_BEGIN;
               end
            end
            ST_BEGIN: begin
               if (mem_ready) begin
                  cp_len_q <= cp_len;
                  state    <= ST_COPY;
               end
            end
            ST_COPY: begin
               if (tmr_expired) state <= ST_DONE;
            end
            ST_DONE: begin
               done_word <= '0;
               done_word[DW_LEN_W-1:0] <= DW_LEN_W'(cp_len_q);
               done_word[DW_FLAG_LSB +: FLAG_W] <= flags_q;
               done_word[DW_CMPL] <= 1'b1;
               if (last) begin
                  have_part <= 1'b0;
                  rem       <= '0;
               end else begin
                  done_word[DW_MORE] <= 1'b1;
                  rem    <= rem - cp_len_q;
                  offset <= offset + cp_len_q;
               end
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   rxdma_copy_timer #(
      .LEN_W(LEN_W), .LAT_BASE(LAT_BASE), .LAT_PER64(LAT_PER64), .LAT_W(LAT_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .load(accept), .len(cp_len),
      .tick(state == ST_COPY), .expired(tmr_expired)
   );

   rxdma_read_port #(.CNT_W(CNT_W)) u_rdport (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
      .engine_idle(state == ST_IDLE), .done_word(done_word),
      .fifo_count(fifo_count), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   a_r2_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |=> ($stable(buf_addr) && $stable(buf_len)));
   a_r3_wait_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !pkt_valid && !have_part) |=> (state == ST_WAIT));
   a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_len <= buf_len && mem_len <= rem));
   a_r8_pop_only_last: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_pop |-> (irq_rxdata && rem == cp_len_q));
   a_r9_irq_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rxdata |=> (state == ST_IDLE && !irq_rxdata));
   a_r13_proto_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !have_part && pkt_valid) |-> !(pkt_flags[FL_TCP] && pkt_flags[FL_UDP]));

endmodule

// File: tb/rxdma_engine_bench.sv
module rxdma_engine_bench;
   localparam int ADDR_W = 32, LEN_W = 16, CNT_W = 10, LB = 4, LP = 2;

   logic clk = 1'b0, rst_n = 1'b0, rx_enable = 1'b1;
   logic req_wr = 1'b0, mem_ready = 1'b1, rd_req = 1'b0;
   logic [63:0] req_word = '0;
   logic req_err, pkt_pop, mem_valid, rd_valid, irq_rxdata;
   logic [ADDR_W-1:0] mem_addr;
   logic [LEN_W-1:0] mem_len, mem_offset;
   logic [63:0] rd_data;

   // queue model
   int q_len [0:15];
   int q_flg [0:15];
   int head = 0, tail = 0, extra = 0;
   logic pkt_valid;
   logic [LEN_W-1:0] pkt_len;
   logic [5:0] pkt_flags;
   logic [CNT_W-1:0] fifo_count;
   assign pkt_valid  = (tail != head);
   assign pkt_len    = LEN_W'(q_len[head % 16]);
   assign pkt_flags  = 6'(q_flg[head % 16]);
   assign fifo_count = CNT_W'(tail - head + extra);

   int checks = 0, fails = 0;
   int exp_rem = 0, exp_off = 0, exp_flg = 0;

   always #5 clk = ~clk;

   always @(negedge clk) if (pkt_pop) head = head + 1;

   rxdma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
                  .LAT_BASE(LB), .LAT_PER64(LP), .LAT_W(20)) u_rxdma_engine (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .req_wr(req_wr),
      .req_word(req_word), .req_err(req_err), .pkt_valid(pkt_valid),
      .pkt_len(pkt_len), .pkt_flags(pkt_flags), .pkt_pop(pkt_pop),
      .fifo_count(fifo_count), .mem_valid(mem_valid), .mem_ready(mem_ready),
      .mem_addr(mem_addr), .mem_len(mem_len), .mem_offset(mem_offset),
      .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
      .irq_rxdata(irq_rxdata));

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input int len, input int flg);
      q_len[tail % 16] = len;
      q_flg[tail % 16] = flg;
      tail = tail + 1;
   endtask

   task automatic issue(input int buf_len, input int addr);
      req_word = {16'h0, 16'(buf_len), 32'(addr)};
      req_wr = 1'b1;
      @(negedge clk);
      req_wr = 1'b0;
   endtask

   task automatic do_read(output logic [63:0] d);
      int n = 0;
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      while (!rd_valid && n < 100) begin @(negedge clk); n++; end
      d = rd_data;
   endtask

   // waits for handshake and completion, checks the port and the timing
   task automatic finish(input int buf_len, input int addr);
      int n = 0, cl, lat;
      logic [63:0] d;
      if (exp_rem == 0) begin
         exp_rem = q_len[head % 16]; exp_flg = q_flg[head % 16]; exp_off = 0;
      end
      cl = (buf_len < exp_rem) ? buf_len : exp_rem;
      while (!(mem_valid && mem_ready) && n < 200) begin @(negedge clk); n++; end
      check("R4 mem_addr", mem_addr, addr);
      check("R4 mem_len", mem_len, cl);
      check("R7 mem_offset", mem_offset, exp_off);
      n = 0;
      while (!irq_rxdata && n < 500) begin
         @(negedge clk); n++;
         if (pkt_pop && cl != exp_rem) check("R8 pop on partial", 1, 0);
      end
      lat = LB + ((cl + 63) / 64) * LP;
      check("R5 latency", n, lat + 2);
      check("R8 pop on last", pkt_pop, (cl == exp_rem));
      @(negedge clk);
      check("R9 irq one pulse", irq_rxdata, 0);
      do_read(d);
      check("R6 length", d[15:0], cl);
      check("R6 flags", d[21:16], exp_flg);
      check("R7 more", d[30], (cl != exp_rem));
      check("R6 complete", d[31], 1);
      check("R10 count", d[39:32], ((tail - head + extra) > 255) ? 255 : (tail - head + extra));
      exp_rem = exp_rem - cl;
      exp_off = exp_off + cl;
   endtask

   // {pkt_len[39:24], flags[23:16], buf_len[15:0]}
   localparam logic [39:0] VEC [6] = '{
      {16'd100, 8'h03, 16'd200},
      {16'd300, 8'h25, 16'd128},
      {16'd0,   8'h00, 16'd128},
      {16'd0,   8'h00, 16'd128},
      {16'd64,  8'h09, 16'd64},
      {16'd65,  8'h00, 16'd1000}
   };

   initial begin
      #200000000;
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [63:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check("R12 mem_valid", mem_valid, 0);
      check("R12 irq", irq_rxdata, 0);
      check("R12 pop", pkt_pop, 0);
      do_read(d);
      check("R12 done word", d, 0);

      foreach (VEC[i]) begin
         if (VEC[i][39:24] != 0) push(int'(VEC[i][39:24]), int'(VEC[i][23:16]));
         issue(int'(VEC[i][15:0]), 32'h1000 + i * 32'h100);
         finish(int'(VEC[i][15:0]), 32'h1000 + i * 32'h100);
      end

      // R3 empty queue: engine waits
      issue(50, 32'h8000);
      repeat (10) begin
         check("R3 wait empty", mem_valid, 0);
         @(negedge clk);
      end
      push(40, 6'h05);
      finish(50, 32'h8000);

      // R2 busy write and R11 held read
      push(90, 6'h03);
      mem_ready = 1'b0;
      issue(90, 32'h9000);
      repeat (3) @(negedge clk);
      req_word = {16'h0, 16'd10, 32'hDEAD0};
      req_wr = 1'b1;
      #1 check("R2 req_err", req_err, 1);
      @(negedge clk);
      req_wr = 1'b0;
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      repeat (4) begin
         check("R11 held", rd_valid, 0);
         @(negedge clk);
      end
      check("R2 addr kept", mem_addr, 32'h9000);
      check("R2 len kept", mem_len, 90);
      mem_ready = 1'b1;
      while (!irq_rxdata) @(negedge clk);
      @(negedge clk);
      check("R11 not early", rd_valid, 0);
      @(negedge clk);
      check("R11 answered", rd_valid, 1);
      check("R11 fresh word", rd_data[31:0], 32'h8003_005A);
      exp_rem = 0;

      // R10 saturation
      extra = 400;
      do_read(d);
      check("R10 saturated", d[39:32], 255);
      extra = 0;

      // R1 disabled receive: no write, word cleared
      push(30, 0);
      rx_enable = 1'b0;
      issue(30, 32'hA000);
      repeat (10) begin
         check("R1 disabled no write", mem_valid, 0);
         @(negedge clk);
      end
      do_read(d);
      check("R1 cleared word", d[31:0], 0);
      rx_enable = 1'b1;
      issue(30, 32'hA000);
      finish(30, 32'hA000);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule